// File: doc/BRIEF.md
# PCI Configuration Cycle Translator

This block sits in a host bridge between the processor access path and a PCI master engine. The processor first loads a 32-bit configuration address word through an address port. That word holds an enable flag, a target bus, a device, a function and a dword register index. A later read or write of a separate data port turns into exactly one PCI configuration transaction. The block chooses the transaction kind. A target on the local bus (a programmable bus number) gets a type 0 cycle, with a one-hot device-select line in the upper AD bits. A target on any other bus gets a type 1 cycle, which a PCI-to-PCI bridge can forward. The block hands the formed AD word to the external engine and returns the completion to the processor.

Both processor request and processor response are valid/ready streams. A request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` stays low from acceptance until the response has been taken, so at most one access is in progress. A response, once offered, holds its data unchanged until `cpu_rsp_ready` is high. Toward the engine, `cfg_req_valid` and its fields hold steady until `cfg_req_ready` is high. The engine then reports the outcome with a one-cycle `eng_done` pulse, flagged `eng_abort` on a master-abort. The engine has no way to stall that report.

Several cases issue no cycle and complete at once. These are: the enable flag clear, device number 31, and a local-bus device with no select line. Reads in those cases return all ones and writes are dropped. Accesses that hit neither port also issue no cycle and return zero.

Top module: `pci_cfg_xlator`

## Requirements
- R1: A write to any byte address inside the address-port window (`APORT_BASE` up to `APORT_BASE + 2**APORT_SPAN_LOG2 - 1`) stores the configuration word. A read anywhere in that window returns it. Bit 31 is enable, bits 23:16 bus, 15:11 device, 10:8 function and 7:2 dword register. Bits 30:24 and 1:0 read as zero, and the reset value is zero.
- R2: A data-port access while the stored enable bit is 0 issues no configuration cycle. A read returns 32'hFFFF_FFFF and a write is dropped with a completion whose data is zero.
- R3: A data-port access while the stored device number is 5'b11111 issues no configuration cycle, with the same completion values as R2.
- R4: When the stored bus equals `local_bus`, the cycle is type 0. `cfg_req_type1` is 0, AD[1:0]=00, AD[7:2] holds the register and AD[10:8] the function, and AD[31:11] has exactly bit 11+device set.
- R5: When the stored bus differs from `local_bus`, the cycle is type 1 with `cfg_req_type1`=1 and AD = {8'h00, bus, device, function, register, 2'b01}.
- R6: A type 0 target with device number 21 to 30 has no select line. It issues no cycle and completes like a master-abort: a read returns all ones and a write completes with zero.
- R7: When the engine reports `eng_abort` with `eng_done`, a read completes with 32'hFFFF_FFFF and a write completes with zero. This applies to both cycle types.
- R8: A successful configuration read returns `eng_rdata` sampled with `eng_done`. A configuration write presents `cfg_req_write`=1 and `cfg_req_wdata` equal to the processor write data.
- R9: Only one access is outstanding. `cpu_req_ready` is low from the cycle after acceptance until the cycle after the response handshake. A request offered meanwhile, including an address-port write, has no effect.
- R10: `cfg_req_valid` with its AD, type, write flag and data stays constant until `cfg_req_ready`. `cpu_rsp_valid` with `cpu_rsp_rdata` stays constant until `cpu_rsp_ready`.
- R11: An access outside both windows issues no cycle. A read returns zero and the address word is unchanged.
- R12: After reset `cpu_req_ready` is 1 and both valids are 0. An access that issues no cycle raises `cpu_rsp_valid` in the cycle after acceptance. A forwarded access raises `cfg_req_valid` in that cycle, and raises `cpu_rsp_valid` in the cycle after the `eng_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_bus | input | 8 | Bus number treated as local (type 0) |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block can take a request |
| cpu_req_addr | input | 32 | Processor byte address |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_wdata | input | 32 | Processor write data |
| cpu_rsp_valid | output | 1 | Completion valid |
| cpu_rsp_ready | input | 1 | Processor takes the completion |
| cpu_rsp_rdata | output | 32 | Read data (zero on writes) |
| cfg_req_valid | output | 1 | Configuration cycle request to the engine |
| cfg_req_ready | input | 1 | Engine takes the request |
| cfg_req_ad | output | 32 | Address phase AD word |
| cfg_req_type1 | output | 1 | 1 = type 1 cycle, 0 = type 0 |
| cfg_req_write | output | 1 | 1 = configuration write |
| cfg_req_wdata | output | 32 | Configuration write data |
| eng_done | input | 1 | One-cycle pulse: cycle finished |
| eng_abort | input | 1 | With eng_done: master-abort |
| eng_rdata | input | 32 | With eng_done: read data |

## Verification
Every result is due a fixed number of edges after its cause. The engine request or the immediate completion follows one edge after acceptance. The forwarded completion follows one edge after the `eng_done` pulse. `cpu_req_ready` returns one edge after the response handshake. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge from those same inputs. On every falling edge it compares the ready and valid outputs, and the data of whatever stream is valid, against the model. Any early, late or missing result therefore shows as a mismatch on the exact cycle it occurs. Varied delays on `cfg_req_ready`, `eng_done` and `cpu_rsp_ready` stretch each hold window to show the R10 stability.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int PCX_AD_W   = 32;
  localparam int PCX_BUS_W  = 8;
  localparam int PCX_DEV_W  = 5;
  localparam int PCX_FN_W   = 3;
  localparam int PCX_REG_W  = 6;
  localparam logic [PCX_AD_W-1:0] PCX_ONES = '1;
  localparam logic [PCX_DEV_W-1:0] PCX_DEV_RSVD = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} pcx_state_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_APORT, TGT_DPORT} pcx_target_e;

  typedef struct packed {
    logic                 en;
    logic [PCX_BUS_W-1:0] bus;
    logic [PCX_DEV_W-1:0] dev;
    logic [PCX_FN_W-1:0]  fn;
    logic [PCX_REG_W-1:0] dreg;
  } pcx_cfgaddr_t;
endpackage

// File: rtl/pcx_port_decode.sv
module pcx_port_decode
  import pcx_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] A_BASE = 32'hFEC0_0000,
  parameter int A_LOG2 = 21,
  parameter logic [AW-1:0] D_BASE = 32'hFEE0_0000,
  parameter int D_LOG2 = 20
) (
  input  logic [AW-1:0] addr,
  output pcx_target_e   target
);
  logic a_hit, d_hit;

  assign a_hit = (addr[AW-1:A_LOG2] == A_BASE[AW-1:A_LOG2]);
  assign d_hit = (addr[AW-1:D_LOG2] == D_BASE[AW-1:D_LOG2]);

  always_comb begin
    if (a_hit)      target = TGT_APORT;
    else if (d_hit) target = TGT_DPORT;
    else            target = TGT_NONE;
  end
endmodule

// File: rtl/pcx_addr_reg.sv
module pcx_addr_reg
  import pcx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PCX_AD_W-1:0] wdata,
  output pcx_cfgaddr_t        q,
  output logic [PCX_AD_W-1:0] view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q.en   <= wdata[31];
      q.bus  <= wdata[23:16];
      q.dev  <= wdata[15:11];
      q.fn   <= wdata[10:8];
      q.dreg <= wdata[7:2];
    end
  end

  assign view = {q.en, 7'd0, q.bus, q.dev, q.fn, q.dreg, 2'b00};
endmodule

// File: rtl/pcx_cycle_former.sv
module pcx_cycle_former
  import pcx_pkg::*;
(
  input  pcx_cfgaddr_t         ca,
  input  logic [PCX_BUS_W-1:0] local_bus,
  output logic                 is_type1,
  output logic                 blocked,
  output logic [PCX_AD_W-1:0]  ad
);
  localparam int LOW_W     = PCX_FN_W + PCX_REG_W + 2;
  localparam int NUM_IDSEL = PCX_AD_W - LOW_W;

  logic [NUM_IDSEL-1:0] idsel;
  logic                 no_line;

  for (genvar g = 0; g < NUM_IDSEL; g++) begin : g_idsel
    assign idsel[g] = (ca.dev == PCX_DEV_W'(g));
  end

  assign is_type1 = (ca.bus != local_bus);
  assign no_line  = !is_type1 && (int'(ca.dev) >= NUM_IDSEL);
  assign blocked  = !ca.en || (ca.dev == PCX_DEV_RSVD) || no_line;

  always_comb begin
    if (is_type1)
      ad = {{(PCX_AD_W-PCX_BUS_W-PCX_DEV_W-LOW_W){1'b0}}, ca.bus, ca.dev, ca.fn, ca.dreg, 2'b01};
    else
      ad = {idsel, ca.fn, ca.dreg, 2'b00};
  end
endmodule

// File: rtl/pcx_seq.sv
module pcx_seq
  import pcx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_req_write,
  input  logic [PCX_AD_W-1:0] cpu_req_wdata,
  input  pcx_target_e         target,
  input  logic [PCX_AD_W-1:0] aport_view,
  input  logic                blocked,
  input  logic                is_type1,
  input  logic [PCX_AD_W-1:0] ad,
  output logic                aport_wr,
  output logic                cfg_req_valid,
  input  logic                cfg_req_ready,
  output logic [PCX_AD_W-1:0] cfg_req_ad,
  output logic                cfg_req_type1,
  output logic                cfg_req_write,
  output logic [PCX_AD_W-1:0] cfg_req_wdata,
  input  logic                eng_done,
  input  logic                eng_abort,
  input  logic [PCX_AD_W-1:0] eng_rdata,
  output logic                cpu_rsp_valid,
  input  logic                cpu_rsp_ready,
  output logic [PCX_AD_W-1:0] cpu_rsp_rdata
);
  pcx_state_e          state;
  logic                accept;
  logic [PCX_AD_W-1:0] ad_q, wdata_q, rsp_q;
  logic                type1_q, write_q;

  assign accept        = cpu_req_valid && (state == ST_IDLE);
  assign cpu_req_ready = (state == ST_IDLE);
  assign aport_wr      = accept && (target == TGT_APORT) && cpu_req_write;
  assign cfg_req_valid = (state == ST_ISSUE);
  assign cpu_rsp_valid = (state == ST_RESP);
  assign cfg_req_ad    = ad_q;
  assign cfg_req_type1 = type1_q;
  assign cfg_req_write = write_q;
  assign cfg_req_wdata = wdata_q;
  assign cpu_rsp_rdata = rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ad_q    <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
      type1_q <= 1'b0;
      write_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          write_q <= cpu_req_write;
          unique case (target)
            TGT_APORT: begin
              rsp_q <= cpu_req_write ? '0 : aport_view;
              state <= ST_RESP;
            end
            TGT_DPORT: begin
              if (blocked) begin
                rsp_q <= cpu_req_write ? '0 : PCX_ONES;
                state <= ST_RESP;
              end else begin
                ad_q    <= ad;
                type1_q <= is_type1;
                wdata_q <= cpu_req_wdata;
                state   <= ST_ISSUE;
              end
            end
            default: begin
              rsp_q <= '0;
              state <= ST_RESP;
            end
          endcase
        end
        ST_ISSUE: if (cfg_req_ready) state <= ST_WAIT;
        ST_WAIT: if (eng_done) begin
          if (write_q)        rsp_q <= '0;
          else if (eng_abort) rsp_q <= PCX_ONES;
          else                rsp_q <= eng_rdata;
          state <= ST_RESP;
        end
        default: if (cpu_rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  // R9: a request to the engine only starts from a processor access just taken
  a_r9_issue_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) |-> $past(cpu_req_valid));
  // R9: never a completion and an engine request at once
  a_r9_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> !cpu_rsp_valid && !cpu_req_ready);
  // R10: engine request held under back-pressure
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_ad)
      && $stable(cfg_req_write) && $stable(cfg_req_wdata) && $stable(cfg_req_type1));
  // R10: completion held under back-pressure
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata));
  // R7: master-aborted read returns all ones
  a_r7_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) && eng_done && eng_abort && !cfg_req_write
      |=> cpu_rsp_valid && (cpu_rsp_rdata == PCX_ONES));
  // R4: type 0 AD word form
  a_r4_type0_form: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_type1 |-> (cfg_req_ad[1:0] == 2'b00)
      && ($countones(cfg_req_ad[PCX_AD_W-1:11]) == 1));
  // R5: type 1 AD word form
  a_r5_type1_form: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && cfg_req_type1 |-> (cfg_req_ad[1:0] == 2'b01)
      && (cfg_req_ad[PCX_AD_W-1:24] == '0));
endmodule

// File: rtl/pci_cfg_xlator.sv
module pci_cfg_xlator
  import pcx_pkg::*;
#(
  parameter logic [31:0] APORT_BASE      = 32'hFEC0_0000,
  parameter int          APORT_SPAN_LOG2 = 21,
  parameter logic [31:0] DPORT_BASE      = 32'hFEE0_0000,
  parameter int          DPORT_SPAN_LOG2 = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  local_bus,
  input  logic        cpu_req_valid,
  output logic        cpu_req_ready,
  input  logic [31:0] cpu_req_addr,
  input  logic        cpu_req_write,
  input  logic [31:0] cpu_req_wdata,
  output logic        cpu_rsp_valid,
  input  logic        cpu_rsp_ready,
  output logic [31:0] cpu_rsp_rdata,
  output logic        cfg_req_valid,
  input  logic        cfg_req_ready,
  output logic [31:0] cfg_req_ad,
  output logic        cfg_req_type1,
  output logic        cfg_req_write,
  output logic [31:0] cfg_req_wdata,
  input  logic        eng_done,
  input  logic        eng_abort,
  input  logic [31:0] eng_rdata
);
  pcx_target_e         tgt;
  pcx_cfgaddr_t        ca;
  logic [PCX_AD_W-1:0] aview, ad;
  logic                aport_wr, blocked, is_type1;

  pcx_port_decode #(
    .AW(PCX_AD_W), .A_BASE(APORT_BASE), .A_LOG2(APORT_SPAN_LOG2),
    .D_BASE(DPORT_BASE), .D_LOG2(DPORT_SPAN_LOG2)
  ) u_decode (
    .addr(cpu_req_addr), .target(tgt)
  );

  pcx_addr_reg u_areg (
    .clk(clk), .rst_n(rst_n), .wr_en(aport_wr), .wdata(cpu_req_wdata),
    .q(ca), .view(aview)
  );

  pcx_cycle_former u_form (
    .ca(ca), .local_bus(local_bus), .is_type1(is_type1),
    .blocked(blocked), .ad(ad)
  );

  pcx_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_wdata(cpu_req_wdata),
    .target(tgt), .aport_view(aview), .blocked(blocked),
    .is_type1(is_type1), .ad(ad), .aport_wr(aport_wr),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_ad(cfg_req_ad), .cfg_req_type1(cfg_req_type1),
    .cfg_req_write(cfg_req_write), .cfg_req_wdata(cfg_req_wdata),
    .eng_done(eng_done), .eng_abort(eng_abort), .eng_rdata(eng_rdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata)
  );

  // R2: enable clear means an immediate completion and no engine request
  a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && (tgt == TGT_DPORT) && !ca.en
      |=> !cfg_req_valid && cpu_rsp_valid
        && (cpu_rsp_rdata == ($past(cpu_req_write) ? '0 : PCX_ONES)));
  // R3: reserved device number means no engine request
  a_r3_dev_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && (tgt == TGT_DPORT) && (ca.dev == PCX_DEV_RSVD)
      |=> !cfg_req_valid && cpu_rsp_valid);
  // R1: address port readback has its reserved bits clear
  a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && (tgt == TGT_APORT) && !cpu_req_write
      |=> cpu_rsp_valid && (cpu_rsp_rdata[30:24] == '0) && (cpu_rsp_rdata[1:0] == '0));
  // R11: a miss on both windows completes with zero
  a_r11_outside: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && (tgt == TGT_NONE)
      |=> cpu_rsp_valid && !cfg_req_valid && (cpu_rsp_rdata == '0));
endmodule

// File: tb/test_pci_cfg_xlator.sv
module test_pci_cfg_xlator;
  localparam logic [31:0] AB = 32'hFEC0_0000;
  localparam logic [31:0] DB = 32'hFEE0_0000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  local_bus = 8'h03;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_rsp_ready = 1'b0, cfg_req_ready = 1'b0;
  logic        eng_done = 1'b0, eng_abort = 1'b0;
  logic [31:0] eng_rdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid, cfg_req_valid, cfg_req_type1, cfg_req_write;
  logic [31:0] cpu_rsp_rdata, cfg_req_ad, cfg_req_wdata;

  always #2.5 clk = ~clk;

  pci_cfg_xlator i_pci_cfg_xlator (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string cur_tag = "R12";

  // behavioural reference model
  logic        m_ready, m_cfg_valid, m_wait, m_rsp_valid, m_cfg_t1, m_cfg_wr, m_wr;
  logic [31:0] m_aw, m_cfg_ad, m_cfg_wd, m_rsp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 1; m_cfg_valid = 0; m_wait = 0; m_rsp_valid = 0;
      m_aw = 0; m_cfg_ad = 0; m_cfg_wd = 0; m_rsp = 0; m_cfg_t1 = 0; m_cfg_wr = 0; m_wr = 0;
    end else if (m_rsp_valid) begin
      if (cpu_rsp_ready) begin m_rsp_valid = 0; m_ready = 1; end
    end else if (m_cfg_valid) begin
      if (cfg_req_ready) begin m_cfg_valid = 0; m_wait = 1; end
    end else if (m_wait) begin
      if (eng_done) begin
        m_wait = 0; m_rsp_valid = 1;
        m_rsp = m_wr ? 32'h0 : (eng_abort ? ONES : eng_rdata);
      end
    end else if (m_ready && cpu_req_valid) begin
      m_ready = 0; m_wr = cpu_req_write;
      if (cpu_req_addr >= AB && cpu_req_addr <= AB + 32'h001F_FFFF) begin
        if (cpu_req_write) begin m_aw = cpu_req_wdata & 32'h80FF_FFFC; m_rsp = 0; end
        else m_rsp = m_aw;
        m_rsp_valid = 1;
      end else if (cpu_req_addr >= DB && cpu_req_addr <= DB + 32'h000F_FFFF) begin
        int dv;
        logic t1;
        dv = int'(m_aw[15:11]);
        t1 = (m_aw[23:16] != local_bus);
        if (!m_aw[31] || dv == 31 || (!t1 && dv > 20)) begin
          m_rsp = cpu_req_write ? 32'h0 : ONES; m_rsp_valid = 1;
        end else begin
          m_cfg_valid = 1; m_cfg_t1 = t1; m_cfg_wr = cpu_req_write; m_cfg_wd = cpu_req_wdata;
          if (t1) m_cfg_ad = {8'h00, m_aw[23:2], 2'b01};
          else m_cfg_ad = (32'h1 << (11 + dv)) | (32'(m_aw[10:8]) << 8) | (32'(m_aw[7:2]) << 2);
        end
      end else begin
        m_rsp = 0; m_rsp_valid = 1;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", cur_tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(32'(cpu_req_ready), 32'(m_ready), "cpu_req_ready");
    chk(32'(cfg_req_valid), 32'(m_cfg_valid), "cfg_req_valid");
    chk(32'(cpu_rsp_valid), 32'(m_rsp_valid), "cpu_rsp_valid");
    if (m_cfg_valid) begin
      chk(cfg_req_ad, m_cfg_ad, "cfg_req_ad");
      chk(32'(cfg_req_type1), 32'(m_cfg_t1), "cfg_req_type1");
      chk(32'(cfg_req_write), 32'(m_cfg_wr), "cfg_req_write");
      if (m_cfg_wr) chk(cfg_req_wdata, m_cfg_wd, "cfg_req_wdata");
    end
    if (m_rsp_valid) chk(cpu_rsp_rdata, m_rsp, "cpu_rsp_rdata");
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
    end
  end

  function automatic logic [31:0] mk(input bit en, input int bus, input int dev, input int fn, input int rg);
    return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
  endfunction

  // one processor access with an engine that answers after given delays
  task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input int rdy_dly, input int done_dly, input logic ab,
                        input logic [31:0] rd, input int rsp_dly, input string tag,
                        input bit hammer = 0);
    cur_tag = tag;
    cpu_req_addr = a; cpu_req_write = w; cpu_req_wdata = d; cpu_req_valid = 1;
    @(negedge clk);
    if (hammer) begin
      cpu_req_addr = AB; cpu_req_write = 1; cpu_req_wdata = 32'h80AA_5500;
    end else cpu_req_valid = 0;
    if (cfg_req_valid) begin
      repeat (rdy_dly) @(negedge clk);
      cfg_req_ready = 1; @(negedge clk); cfg_req_ready = 0;
      repeat (done_dly) @(negedge clk);
      eng_done = 1; eng_abort = ab; eng_rdata = rd;
      @(negedge clk);
      eng_done = 0; eng_abort = 0; eng_rdata = 32'h0BAD_0BAD;
    end
    repeat (rsp_dly) @(negedge clk);
    cpu_rsp_ready = 1; @(negedge clk);
    cpu_rsp_ready = 0; cpu_req_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R12 reset";
    chk(32'(cpu_req_ready), 32'h1, "reset ready");
    chk(32'(cfg_req_valid), 32'h0, "reset cfg valid");
    chk(32'(cpu_rsp_valid), 32'h0, "reset rsp valid");
    access(AB, 0, 0, 0, 0, 0, 0, 0, "R1 reset word");
    access(AB + 32'h1234, 1, 32'h7F12_3457, 0, 0, 0, 0, 0, "R1 write");
    access(AB + 32'h001F_FFFC, 0, 0, 0, 0, 0, 0, 1, "R1 readback");
    access(DB, 0, 0, 0, 0, 0, 0, 0, "R2 read disabled");
    access(DB, 1, 32'h1111_2222, 0, 0, 0, 0, 0, "R2 write disabled");
    access(AB, 1, mk(1, 3, 31, 0, 0), 0, 0, 0, 0, 0, "R3 setup");
    access(DB + 4, 0, 0, 0, 0, 0, 0, 0, "R3 dev31 read");
    access(AB, 1, mk(1, 7, 31, 1, 1), 0, 0, 0, 0, 0, "R3 setup remote");
    access(DB, 1, 32'h5, 0, 0, 0, 0, 0, "R3 dev31 write");
    access(AB, 1, mk(1, 3, 5, 2, 17), 0, 0, 0, 0, 0, "R4 setup");
    access(DB, 0, 0, 2, 3, 0, 32'hCAFE_F00D, 2, "R4 R8 R10 type0 read");
    access(DB, 1, 32'h1234_5678, 3, 1, 0, 0, 0, "R8 R10 type0 write");
    access(AB, 1, mk(1, 3, 0, 7, 63), 0, 0, 0, 0, 0, "R4 setup dev0");
    access(DB, 0, 0, 0, 0, 0, 32'h0000_0001, 0, "R4 dev0");
    access(AB, 1, mk(1, 3, 20, 0, 1), 0, 0, 0, 0, 0, "R4 setup dev20");
    access(DB, 0, 0, 1, 0, 0, 32'hA5A5_5A5A, 0, "R4 dev20");
    access(AB, 1, mk(1, 3, 21, 0, 1), 0, 0, 0, 0, 0, "R6 setup");
    access(DB, 0, 0, 0, 0, 0, 0, 0, "R6 dev21 read");
    access(AB, 1, mk(1, 3, 30, 0, 1), 0, 0, 0, 0, 0, "R6 setup dev30");
    access(DB, 1, 32'h9, 0, 0, 0, 0, 0, "R6 dev30 write");
    access(AB, 1, mk(1, 7, 25, 4, 9), 0, 0, 0, 0, 0, "R5 setup");
    access(DB, 0, 0, 1, 2, 0, 32'h1357_9BDF, 1, "R5 type1 read");
    access(DB, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, "R5 type1 write");
    access(DB, 0, 0, 0, 4, 1, 32'h2222_3333, 0, "R7 type1 abort read");
    access(AB, 1, mk(1, 3, 9, 1, 2), 0, 0, 0, 0, 0, "R7 setup");
    access(DB, 0, 0, 0, 1, 1, 32'h4444_5555, 3, "R7 type0 abort read");
    access(DB, 1, 32'h6666_7777, 2, 2, 1, 0, 0, "R7 type0 abort write");
    access(32'h0000_0CF8, 0, 0, 0, 0, 0, 0, 0, "R11 outside read");
    access(32'hFEF0_0000, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R11 outside write");
    access(AB, 0, 0, 0, 0, 0, 0, 0, "R11 word unchanged");
    access(DB, 0, 0, 2, 3, 0, 32'h7777_8888, 2, "R9 busy hammer", 1);
    access(AB, 0, 0, 0, 0, 0, 0, 0, "R9 word unchanged");
    local_bus = 8'h07;
    access(AB, 1, mk(1, 7, 12, 3, 40), 0, 0, 0, 0, 0, "R4 setup new local");
    access(DB, 0, 0, 0, 0, 0, 32'h0F0F_0F0F, 0, "R4 R12 local bus moved");
    local_bus = 8'h00;
    access(DB, 0, 0, 0, 0, 0, 32'hF0F0_F0F0, 0, "R5 R12 now remote");
    report();
  end
endmodule